// File: doc/BRIEF.md
# Integer Minimum/Maximum Unit with Condition Flags

This block is a purely combinational datapath that returns the smaller or the larger of two 64-bit register operands. A 3-bit mode field picks one of eight variants: minimum or maximum, signed or unsigned, and full doubleword or low word. Decode and register file access sit outside the block. A separate flag tells the unit that the instruction's first register field was zero. In that case the first operand is the constant zero and not the register's contents.

All eight variants share one unsigned less-than comparator. Each operand is first reshaped. In word mode its low half is moved into the upper half with zeros below. In signed mode its top bit is inverted. Maximum mode swaps the two reshaped operands before the compare. The selected output is always the complete 64-bit source value, even in word mode.

When the record input is set, the unit also produces a 4-bit condition field. This field states whether the first operand was less than, greater than or equal to the second, using the mode's width and signedness. A summary-overflow bit supplied by the caller is appended as the last bit.

Top module: `int_minmax_unit`

## Requirements
- R1: The mode field encodes the variant bitwise. mode[0]=1 selects word width (0 selects doubleword). mode[1]=1 selects signed (0 selects unsigned). mode[2]=1 selects maximum (0 selects minimum).
- R2: In doubleword unsigned mode, `result` is the operand with the smaller unsigned value for a minimum, and the operand with the larger unsigned value for a maximum.
- R3: In signed modes the operands are ordered as two's complement numbers. For example, 0x8000_0000_0000_0000 is the smallest doubleword value and 0x8000_0000 is the smallest word value.
- R4: In word modes only bits [31:0] of each operand take part in the ordering. Differences in bits [63:32] never change the choice.
- R5: `result` is always the full 64-bit value of the chosen operand, including its upper half in word modes.
- R6: When `ra_is_zero` is 1, the first operand is 0 in both the ordering and the result, whatever the value on `ra_val`.
- R7: When the two operands compare equal under the mode's width and signedness, `result` is the second operand `rb_val`.
- R8: When `rc` is 1, `cr_out` is {lt, gt, eq, so_in} in bits [3:0]. The value is 4'b100s if a<b, 4'b010s if a>b and 4'b001s if a==b, where s is `so_in`.
- R9: When `rc` is 0, `cr_out` is 4'b0000.
- R10: The condition field compares the first operand with the second, using the mode's width and signedness. It is the same for the minimum and maximum variants of a mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ra_val | input | 64 | First register operand |
| rb_val | input | 64 | Second register operand |
| ra_is_zero | input | 1 | First register field was zero; use constant 0 as first operand |
| mode | input | 3 | Variant select: bit0 word, bit1 signed, bit2 max |
| rc | input | 1 | Record bit; enables the condition field |
| so_in | input | 1 | Summary-overflow bit appended to the condition field |
| result | output | 64 | Selected full-width operand |
| cr_out | output | 4 | Condition field {lt, gt, eq, so} or zero |

## Verification
Every vector is applied under all eight modes.

- The most-negative doubleword and word against small positives separate the signed variants from the unsigned ones: the signed and unsigned orderings disagree on these values.
- Operand pairs whose upper halves differ while their low words are equal (or reversed) separate the word variants from the doubleword ones. They also show whether the full source value is forwarded.
- Equal operands, a zero first-field flag carrying garbage on `ra_val`, and toggled `rc`/`so_in` cover the tie rule, the constant-zero operand and the condition field in each mode.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned CR_W      = 4;
  localparam int unsigned MB_WORD   = 0;
  localparam int unsigned MB_SIGNED = 1;
  localparam int unsigned MB_MAX    = 2;

  // Condition field layout: lt at bit 3, gt at bit 2, eq at bit 1, so at bit 0
  function automatic logic [CR_W-1:0] cr_pack(input logic lt, input logic gt,
                                               input logic eq, input logic so);
    return {lt, gt, eq, so};
  endfunction
endpackage

// File: rtl/mm_operand_prep.sv
module mm_operand_prep #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_in,
  input  logic         word_mode,
  input  logic         signed_mode,
  output logic [W-1:0] y_out
);
  localparam int unsigned HALF = W / 2;
  logic [W-1:0] shifted;

  // word mode: low half moved up, zeros below, so the full compare sees only it
  always_comb begin
    shifted = word_mode ? {x_in[HALF-1:0], {HALF{1'b0}}} : x_in;
    y_out   = signed_mode ? {~shifted[W-1], shifted[W-2:0]} : shifted;
  end
endmodule

// File: rtl/mm_ult_compare.sv
module mm_ult_compare #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         lt,
  output logic         eq
);
  always_comb begin
    lt = (lhs < rhs);
    eq = (lhs == rhs);
  end
endmodule

// File: rtl/int_minmax_unit.sv
module int_minmax_unit
  import imm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic              ra_is_zero,
  input  logic [MODE_W-1:0] mode,
  input  logic              rc,
  input  logic              so_in,
  output logic [XLEN-1:0]   result,
  output logic [CR_W-1:0]   cr_out
);
  localparam int unsigned NOPS = 2;

  logic            is_word, is_signed, is_max;
  logic [XLEN-1:0] a_eff;
  logic [XLEN-1:0] raw_op  [NOPS];
  logic [XLEN-1:0] prep_op [NOPS];
  logic [XLEN-1:0] cmp_l, cmp_r;
  logic            lt_lr, eq_lr;
  logic            a_lt_b, a_gt_b;

  assign is_word   = mode[MB_WORD];
  assign is_signed = mode[MB_SIGNED];
  assign is_max    = mode[MB_MAX];

  assign a_eff     = ra_is_zero ? '0 : ra_val;
  assign raw_op[0] = a_eff;
  assign raw_op[1] = rb_val;

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    mm_operand_prep #(.W(XLEN)) u_prep (
      .x_in        (raw_op[g]),
      .word_mode   (is_word),
      .signed_mode (is_signed),
      .y_out       (prep_op[g])
    );
  end

  // maximum: swap so that less-than answers greater-than
  assign cmp_l = is_max ? prep_op[1] : prep_op[0];
  assign cmp_r = is_max ? prep_op[0] : prep_op[1];

  mm_ult_compare #(.W(XLEN)) u_cmp (
    .lhs (cmp_l),
    .rhs (cmp_r),
    .lt  (lt_lr),
    .eq  (eq_lr)
  );

  // undo the swap for the condition field
  assign a_lt_b = is_max ? (~lt_lr & ~eq_lr) : lt_lr;
  assign a_gt_b = is_max ? lt_lr : (~lt_lr & ~eq_lr);

  assign result = lt_lr ? a_eff : rb_val;
  assign cr_out = rc ? cr_pack(a_lt_b, a_gt_b, eq_lr, so_in) : '0;
endmodule

// File: rtl/int_minmax_unit_checker.sv
module int_minmax_unit_checker
  import imm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic [XLEN-1:0]   ra_val,
  input logic [XLEN-1:0]   rb_val,
  input logic              ra_is_zero,
  input logic [MODE_W-1:0] mode,
  input logic              rc,
  input logic              so_in,
  input logic [XLEN-1:0]   result,
  input logic [CR_W-1:0]   cr_out,
  input logic [XLEN-1:0]   a_eff,
  input logic              eq_lr
);
  always_comb begin
    if (!$isunknown({ra_val, rb_val, ra_is_zero, mode, rc, so_in})) begin
      p_zero_operand_r6: assert (!ra_is_zero || a_eff == '0);
      p_result_source_r5: assert (result == a_eff || result == rb_val);
      p_equal_pick_b_r7: assert (!eq_lr || result == rb_val);
      p_cr_shape_r8: assert (!rc || ($onehot(cr_out[3:1]) && cr_out[0] == so_in));
      p_cr_clear_r9: assert (rc || cr_out == '0);
      p_udword_min_r2: assert (!(mode == 3'b000 && a_eff < rb_val) || result == a_eff);
      p_udword_max_r2: assert (!(mode == 3'b100 && a_eff > rb_val) || result == a_eff);
    end
  end
endmodule

bind int_minmax_unit int_minmax_unit_checker #(.XLEN(XLEN)) u_chk (
  .ra_val     (ra_val),
  .rb_val     (rb_val),
  .ra_is_zero (ra_is_zero),
  .mode       (mode),
  .rc         (rc),
  .so_in      (so_in),
  .result     (result),
  .cr_out     (cr_out),
  .a_eff      (a_eff),
  .eq_lr      (eq_lr)
);

// File: tb/tb_int_minmax_unit.sv
`timescale 1ns/1ps
module tb_int_minmax_unit;
  logic        clk = 1'b0;
  logic [63:0] ra_val = '0, rb_val = '0;
  logic        ra_is_zero = 1'b0, rc = 1'b0, so_in = 1'b0;
  logic [2:0]  mode = '0;
  logic [63:0] result;
  logic [3:0]  cr_out;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic [63:0] q_res[$];
  logic [3:0]  q_cr[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  int_minmax_unit dut (
    .ra_val(ra_val), .rb_val(rb_val), .ra_is_zero(ra_is_zero), .mode(mode),
    .rc(rc), .so_in(so_in), .result(result), .cr_out(cr_out)
  );

  // Independent model using C-style casts; returns -1, 0, +1
  function automatic int order(input logic [63:0] a, input logic [63:0] b,
                               input logic word, input logic sgn);
    longint sa, sb; int sa32, sb32;
    if (word && sgn) begin
      sa32 = a[31:0]; sb32 = b[31:0];
      return (sa32 < sb32) ? -1 : (sa32 > sb32) ? 1 : 0;
    end else if (word) begin
      return (a[31:0] < b[31:0]) ? -1 : (a[31:0] > b[31:0]) ? 1 : 0;
    end else if (sgn) begin
      sa = a; sb = b;
      return (sa < sb) ? -1 : (sa > sb) ? 1 : 0;
    end
    return (a < b) ? -1 : (a > b) ? 1 : 0;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m,
                       input logic raz, input logic r, input logic s, input string tag);
    logic [63:0] aa, er; logic [3:0] ec; int o;
    @(posedge clk); #1;
    ra_val = a; rb_val = b; mode = m; ra_is_zero = raz; rc = r; so_in = s;
    aa = raz ? 64'd0 : a;
    o  = order(aa, b, m[0], m[1]);
    if (m[2]) er = (o > 0) ? aa : b;
    else      er = (o < 0) ? aa : b;
    if (!r)         ec = 4'b0000;
    else if (o < 0) ec = {3'b100, s};
    else if (o > 0) ec = {3'b010, s};
    else            ec = {3'b001, s};
    q_res.push_back(er); q_cr.push_back(ec); q_tag.push_back(tag);
  endtask

  // Monitor: compare outputs on the falling edge
  always @(negedge clk) begin
    if (q_res.size() > 0) begin
      logic [63:0] er; logic [3:0] ec; string tg;
      er = q_res.pop_front(); ec = q_cr.pop_front(); tg = q_tag.pop_front();
      checks += 2;
      if (result !== er) begin
        failures++;
        $display("FAIL %s result mode=%b act=%h exp=%h", tg, mode, result, er);
      end
      if (cr_out !== ec) begin
        failures++;
        $display("FAIL %s cr_out mode=%b act=%b exp=%b", tg, mode, cr_out, ec);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset-like idle state: all zero inputs (R9 cr zero, R7 equal picks b)
    drive(64'd0, 64'd0, 3'b000, 1'b0, 1'b0, 1'b0, "R9 idle");
    for (int m = 0; m < 8; m++) begin
      // R3 most-negative doubleword vs one
      drive(64'h8000_0000_0000_0000, 64'd1, m[2:0], 1'b0, 1'b1, 1'b0, "R3 R1 minneg64");
      // R3 most-negative word vs one, upper halves garbage
      drive(64'h1234_5678_8000_0000, 64'hFFFF_0000_0000_0001, m[2:0], 1'b0, 1'b1, 1'b1, "R3 minneg32");
      // R7 equal values
      drive(64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D, m[2:0], 1'b0, 1'b1, 1'b0, "R7 equal");
      // R4 R5 upper halves differ, low words equal
      drive(64'hAAAA_0000_0000_0042, 64'h0000_5555_0000_0042, m[2:0], 1'b0, 1'b1, 1'b1, "R4 R5 loweq");
      // R4 R5 upper halves ordered opposite to low words
      drive(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, m[2:0], 1'b0, 1'b1, 1'b0, "R4 R5 cross");
      // R2 plain ordering
      drive(64'd100, 64'd7, m[2:0], 1'b0, 1'b1, 1'b0, "R2 R10 basic");
      drive(64'd3, 64'hFFFF_FFFF_FFFF_FFFF, m[2:0], 1'b0, 1'b1, 1'b0, "R2 R3 vs-1");
      // R6 zero register field with garbage on ra_val
      drive(64'h7777_7777_7777_7777, 64'hFFFF_FFFF_FFFF_FFFE, m[2:0], 1'b1, 1'b1, 1'b0, "R6 raz");
      drive(64'h8000_0000_0000_0000, 64'd0, m[2:0], 1'b1, 1'b1, 1'b1, "R6 R7 raz-eq");
      // R9 record bit clear
      drive(64'd5, 64'd9, m[2:0], 1'b0, 1'b0, 1'b1, "R9 norc");
      // R8 R10 condition with so set
      drive(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, m[2:0], 1'b0, 1'b1, 1'b1, "R8 R10 wordedge");
    end
    @(posedge clk); @(posedge clk); @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule